// File: doc/BRIEF.md
# Capability Access Check Unit

This block decides whether a memory access made through a bounded, tagged pointer may go ahead. It gets the pointer's fields (validity tag, sealed flag, base, length, current offset and a 31-bit rights mask) together with the kind of access, an extra signed displacement and the access size in bytes. From these it forms the effective virtual address. It then either grants the access or reports one prioritised fault cause.

The unit sits in front of address translation, so every comparison is made on virtual addresses. The core is combinational. A parameter can add one output register stage to shorten the timing path into the translation logic. A request is presented with `req_valid_i`, and its verdict appears on `rsp_valid_o` after the configured latency. That latency is one cycle by default and zero cycles when the output stage is left out.

Top module: `cap_deref_check`

## Requirements
- R1: After reset, and in every response slot with no request, `rsp_valid_o`, `grant_o` and `cause_o` are 0 and `eff_addr_o` is 0.
- R2: A request whose tag is 0 is answered with cause 1 (tag fault) and no grant, whatever its other fields hold.
- R3: A tagged request whose sealed flag is 1 is answered with cause 2 (seal fault) and no grant.
- R4: A tagged, unsealed request lacking the right for its kind is answered with cause 3 (rights fault). The kind encodings are: load is 0, which needs rights bit 2; store is 1, which needs rights bit 3; fetch is 2, which needs rights bit 1. Kind 3 is reserved and always takes cause 3.
- R5: Otherwise the access is granted only if EA >= base and EA + size <= base + length, with both sides computed at 65 bits. If not, the request is answered with cause 4 (bounds fault).
- R6: An access whose end EA + size exceeds 2^64 is a bounds fault, even when base + length also exceeds 2^64. An access ending exactly at 2^64 may be granted.
- R7: A zero-length capability rejects every access of nonzero size with cause 4. An access of size 0 at EA == base is granted.
- R8: `eff_addr_o` equals base + offset + displacement modulo 2^64 on every response, whether it is granted or faulted.
- R9: `grant_o` is 1 exactly when a response is valid and its cause is 0. The response is due one cycle after the request with the default output register.
- R10: When several faults apply, the reported cause is the first in the order tag, seal, rights, bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| cap_tag_i | input | 1 | Validity tag of the capability |
| cap_sealed_i | input | 1 | Sealed flag of the capability |
| cap_base_i | input | 64 | Lower bound |
| cap_length_i | input | 64 | Extent in bytes |
| cap_offset_i | input | 64 | Offset from base |
| cap_perms_i | input | 31 | Rights mask |
| acc_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| acc_disp_i | input | 64 | Extra displacement, two's complement |
| acc_size_i | input | 5 | Access size in bytes |
| rsp_valid_o | output | 1 | Verdict present |
| grant_o | output | 1 | Access allowed |
| cause_o | output | 3 | 0 none, 1 tag, 2 seal, 3 rights, 4 bounds |
| eff_addr_o | output | 64 | Effective virtual address |

## Verification
Every verdict field, and the effective address, is due on the clock edge after the request is driven. The bench drives stimulus on the falling edge. On the next falling edge it compares all four outputs against a behavioural model evaluated on the previous cycle's inputs, so each comparison lands exactly one register stage after its stimulus. Idle slots are compared the same way against the all-zero response. The bounds corners (last byte, one byte past, below base, the 2^64 edge, zero length) are driven back to back so that each lands in its own slot.

// File: rtl/cap_check_pkg.sv
package cap_check_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_TAG    = 3'd1,
        CAUSE_SEAL   = 3'd2,
        CAUSE_RIGHTS = 3'd3,
        CAUSE_BOUNDS = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    localparam int RIGHT_FETCH_BIT = 1;
    localparam int RIGHT_LOAD_BIT  = 2;
    localparam int RIGHT_STORE_BIT = 3;

endpackage

// File: rtl/cap_addr_gen.sv
module cap_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 5,
    localparam int EXT_W = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] length_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [EXT_W-1:0]  end_o,
    output logic [EXT_W-1:0]  limit_o
);
    // Effective address wraps modulo 2^ADDR_W; the end and the limit carry one extra bit.
    always_comb begin
        ea_o    = base_i + offset_i + disp_i;
        end_o   = {1'b0, ea_o} + {{(EXT_W-SIZE_W){1'b0}}, size_i};
        limit_o = {1'b0, base_i} + {1'b0, length_i};
    end
endmodule

// File: rtl/cap_bounds_cmp.sv
module cap_bounds_cmp #(
    parameter int ADDR_W = 64,
    localparam int EXT_W = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic [EXT_W-1:0]  end_i,
    input  logic [EXT_W-1:0]  limit_i,
    output logic              in_bounds_o
);
    logic below, above, past_top;

    always_comb begin
        below       = ea_i < base_i;
        above       = end_i > limit_i;
        // End beyond 2^ADDR_W: top bit set and any lower bit set.
        past_top    = end_i[ADDR_W] & (|end_i[ADDR_W-1:0]);
        in_bounds_o = !(below || above || past_top);
    end
endmodule

// File: rtl/cap_fault_prio.sv
module cap_fault_prio
    import cap_check_pkg::*;
#(
    parameter int PERM_W = 31
) (
    input  logic              tag_i,
    input  logic              sealed_i,
    input  logic [PERM_W-1:0] perms_i,
    input  kind_e             kind_i,
    input  logic              in_bounds_i,
    output cause_e            cause_o
);
    logic [PERM_W-1:0] need_mask;
    logic              has_right;

    always_comb begin
        need_mask = '0;
        case (kind_i)
            KIND_LOAD:  need_mask[RIGHT_LOAD_BIT]  = 1'b1;
            KIND_STORE: need_mask[RIGHT_STORE_BIT] = 1'b1;
            KIND_FETCH: need_mask[RIGHT_FETCH_BIT] = 1'b1;
            default:    need_mask = '0;
        endcase
        has_right = |(perms_i & need_mask);

        if (!tag_i)            cause_o = CAUSE_TAG;
        else if (sealed_i)     cause_o = CAUSE_SEAL;
        else if (!has_right)   cause_o = CAUSE_RIGHTS;
        else if (!in_bounds_i) cause_o = CAUSE_BOUNDS;
        else                   cause_o = CAUSE_NONE;
    end
endmodule

// File: rtl/cap_deref_check.sv
module cap_deref_check
    import cap_check_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int PERM_W  = 31,
    parameter int SIZE_W  = 5,
    parameter bit REG_OUT = 1'b1,
    localparam int EXT_W  = ADDR_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              cap_tag_i,
    input  logic              cap_sealed_i,
    input  logic [ADDR_W-1:0] cap_base_i,
    input  logic [ADDR_W-1:0] cap_length_i,
    input  logic [ADDR_W-1:0] cap_offset_i,
    input  logic [PERM_W-1:0] cap_perms_i,
    input  logic [1:0]        acc_kind_i,
    input  logic [ADDR_W-1:0] acc_disp_i,
    input  logic [SIZE_W-1:0] acc_size_i,
    output logic              rsp_valid_o,
    output logic              grant_o,
    output logic [2:0]        cause_o,
    output logic [ADDR_W-1:0] eff_addr_o
);
    typedef struct packed {
        logic              valid;
        logic              grant;
        cause_e            cause;
        logic [ADDR_W-1:0] ea;
    } rsp_t;

    logic [ADDR_W-1:0] ea;
    logic [EXT_W-1:0]  acc_end, acc_limit;
    logic              in_bounds;
    cause_e            cause;
    rsp_t              rsp_d, rsp_q;

    cap_addr_gen #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_addr (
        .base_i   (cap_base_i),
        .length_i (cap_length_i),
        .offset_i (cap_offset_i),
        .disp_i   (acc_disp_i),
        .size_i   (acc_size_i),
        .ea_o     (ea),
        .end_o    (acc_end),
        .limit_o  (acc_limit)
    );

    cap_bounds_cmp #(.ADDR_W(ADDR_W)) u_bounds (
        .base_i      (cap_base_i),
        .ea_i        (ea),
        .end_i       (acc_end),
        .limit_i     (acc_limit),
        .in_bounds_o (in_bounds)
    );

    cap_fault_prio #(.PERM_W(PERM_W)) u_prio (
        .tag_i       (cap_tag_i),
        .sealed_i    (cap_sealed_i),
        .perms_i     (cap_perms_i),
        .kind_i      (kind_e'(acc_kind_i)),
        .in_bounds_i (in_bounds),
        .cause_o     (cause)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid_i) begin
            rsp_d.valid = 1'b1;
            rsp_d.cause = cause;
            rsp_d.grant = (cause == CAUSE_NONE);
            rsp_d.ea    = ea;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) rsp_q <= '0;
                else         rsp_q <= rsp_d;
            end
        end else begin : g_comb
            assign rsp_q = rsp_d;
        end
    endgenerate

    assign rsp_valid_o = rsp_q.valid;
    assign grant_o     = rsp_q.grant;
    assign cause_o     = rsp_q.cause;
    assign eff_addr_o  = rsp_q.ea;

endmodule

// File: rtl/cap_deref_check_sva.sv
module cap_deref_check_sva #(
    parameter int ADDR_W  = 64,
    parameter int PERM_W  = 31,
    parameter int SIZE_W  = 5,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic              cap_tag_i,
    input logic              cap_sealed_i,
    input logic [ADDR_W-1:0] cap_base_i,
    input logic [ADDR_W-1:0] cap_length_i,
    input logic [ADDR_W-1:0] cap_offset_i,
    input logic [PERM_W-1:0] cap_perms_i,
    input logic [1:0]        acc_kind_i,
    input logic [ADDR_W-1:0] acc_disp_i,
    input logic [SIZE_W-1:0] acc_size_i,
    input logic              rsp_valid_o,
    input logic              grant_o,
    input logic [2:0]        cause_o,
    input logic [ADDR_W-1:0] eff_addr_o
);
    // Request fields aligned to the response slot.
    logic              tag_q, sealed_q;
    logic [ADDR_W-1:0] base_q, len_q, off_q, disp_q;
    logic [SIZE_W-1:0] size_q;
    logic              tag_v, sealed_v;
    logic [ADDR_W-1:0] base_v, len_v, off_v, disp_v;
    logic [SIZE_W-1:0] size_v;

    always_ff @(posedge clk_i) begin
        tag_q    <= cap_tag_i;
        sealed_q <= cap_sealed_i;
        base_q   <= cap_base_i;
        len_q    <= cap_length_i;
        off_q    <= cap_offset_i;
        disp_q   <= acc_disp_i;
        size_q   <= acc_size_i;
    end

    assign tag_v    = REG_OUT ? tag_q    : cap_tag_i;
    assign sealed_v = REG_OUT ? sealed_q : cap_sealed_i;
    assign base_v   = REG_OUT ? base_q   : cap_base_i;
    assign len_v    = REG_OUT ? len_q    : cap_length_i;
    assign off_v    = REG_OUT ? off_q    : cap_offset_i;
    assign disp_v   = REG_OUT ? disp_q   : acc_disp_i;
    assign size_v   = REG_OUT ? size_q   : acc_size_i;

    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rsp_valid_o |-> (!grant_o && cause_o == 3'd0 && eff_addr_o == '0));

    a_r2_tag_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !tag_v) |-> (cause_o == 3'd1 && !grant_o));

    a_r3_sealed_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && tag_v && sealed_v) |-> (cause_o == 3'd2 && !grant_o));

    a_r7_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && len_v == '0 && size_v != '0) |-> !grant_o);

    a_r8_eff_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> (eff_addr_o == base_v + off_v + disp_v));

    a_r9_grant_iff_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> (grant_o == (cause_o == 3'd0)));

    a_r10_cause_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> (cause_o <= 3'd4));

    a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        REG_OUT |-> (rsp_valid_o == $past(req_valid_i)));

endmodule

bind cap_deref_check cap_deref_check_sva #(
    .ADDR_W(ADDR_W), .PERM_W(PERM_W), .SIZE_W(SIZE_W), .REG_OUT(REG_OUT)
) u_sva (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .cap_tag_i    (cap_tag_i),
    .cap_sealed_i (cap_sealed_i),
    .cap_base_i   (cap_base_i),
    .cap_length_i (cap_length_i),
    .cap_offset_i (cap_offset_i),
    .cap_perms_i  (cap_perms_i),
    .acc_kind_i   (acc_kind_i),
    .acc_disp_i   (acc_disp_i),
    .acc_size_i   (acc_size_i),
    .rsp_valid_o  (rsp_valid_o),
    .grant_o      (grant_o),
    .cause_o      (cause_o),
    .eff_addr_o   (eff_addr_o)
);

// File: tb/cap_deref_check_tb_top.sv
module cap_deref_check_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        cap_tag_i = 1'b0;
    logic        cap_sealed_i = 1'b0;
    logic [63:0] cap_base_i = '0;
    logic [63:0] cap_length_i = '0;
    logic [63:0] cap_offset_i = '0;
    logic [30:0] cap_perms_i = '0;
    logic [1:0]  acc_kind_i = '0;
    logic [63:0] acc_disp_i = '0;
    logic [4:0]  acc_size_i = '0;
    logic        rsp_valid_o, grant_o;
    logic [2:0]  cause_o;
    logic [63:0] eff_addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected response for the slot after the current inputs.
    logic        exp_valid = 1'b0;
    logic        exp_grant = 1'b0;
    logic [2:0]  exp_cause = '0;
    logic [63:0] exp_ea    = '0;
    string       exp_tag   = "R1";

    always #2 clk_i = ~clk_i;

    cap_deref_check dut_i (
        .clk_i, .rst_ni, .req_valid_i, .cap_tag_i, .cap_sealed_i,
        .cap_base_i, .cap_length_i, .cap_offset_i, .cap_perms_i,
        .acc_kind_i, .acc_disp_i, .acc_size_i,
        .rsp_valid_o, .grant_o, .cause_o, .eff_addr_o
    );

    task automatic model(input string tag);
        logic [64:0] last_x, lim_x, top_x;
        logic        right;
        exp_valid = req_valid_i;
        exp_tag   = tag;
        if (!req_valid_i) begin
            exp_grant = 0; exp_cause = 0; exp_ea = 0;
            return;
        end
        exp_ea = cap_base_i + cap_offset_i + acc_disp_i;
        last_x = 65'(exp_ea) + 65'(acc_size_i);
        lim_x  = 65'(cap_base_i) + 65'(cap_length_i);
        top_x  = 65'h1_0000_0000_0000_0000;
        case (acc_kind_i)
            2'd0: right = cap_perms_i[2];
            2'd1: right = cap_perms_i[3];
            2'd2: right = cap_perms_i[1];
            default: right = 1'b0;
        endcase
        if (!cap_tag_i) exp_cause = 3'd1;
        else if (cap_sealed_i) exp_cause = 3'd2;
        else if (!right) exp_cause = 3'd3;
        else if (exp_ea < cap_base_i || last_x > lim_x || last_x > top_x) exp_cause = 3'd4;
        else exp_cause = 3'd0;
        exp_grant = (exp_cause == 3'd0);
    endtask

    task automatic compare();
        checks++;
        if (rsp_valid_o !== exp_valid || grant_o !== exp_grant ||
            cause_o !== exp_cause || eff_addr_o !== exp_ea) begin
            fails++;
            $display("FAIL %s: got v=%0b g=%0b c=%0d ea=%h, expected v=%0b g=%0b c=%0d ea=%h",
                     exp_tag, rsp_valid_o, grant_o, cause_o, eff_addr_o,
                     exp_valid, exp_grant, exp_cause, exp_ea);
        end
    endtask

    // One slot: check the previous request's verdict, then drive the next one.
    task automatic slot(input string tag, input bit v, input bit t, input bit s,
                        input logic [63:0] b, input logic [63:0] l, input logic [63:0] o,
                        input logic [30:0] p, input logic [1:0] k,
                        input logic [63:0] d, input logic [4:0] z);
        @(negedge clk_i);
        compare();
        req_valid_i = v; cap_tag_i = t; cap_sealed_i = s;
        cap_base_i = b; cap_length_i = l; cap_offset_i = o;
        cap_perms_i = p; acc_kind_i = k; acc_disp_i = d; acc_size_i = z;
        model(tag);
    endtask

    localparam logic [30:0] ALL = '1;
    localparam logic [30:0] LD_ONLY = 31'h4;

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: reset state.
        checks++;
        if (rsp_valid_o !== 0 || grant_o !== 0 || cause_o !== 0 || eff_addr_o !== 0) begin
            fails++;
            $display("FAIL R1: reset outputs v=%0b g=%0b c=%0d ea=%h, expected all zero",
                     rsp_valid_o, grant_o, cause_o, eff_addr_o);
        end
        rst_ni = 1'b1;
        model("R1");
        // R9 R8: clean load.
        slot("R9", 1, 1, 0, 64'h1000, 64'h100, 64'h10, ALL, 2'd0, 64'h0, 5'd8);
        // R2 R10: tag clear beats seal, rights and bounds.
        slot("R2", 1, 0, 1, 64'h1000, 64'h0, 64'h900, 31'h0, 2'd1, 64'h0, 5'd8);
        // R3 R10: sealed beats rights.
        slot("R3", 1, 1, 1, 64'h1000, 64'h100, 64'h0, 31'h0, 2'd0, 64'h0, 5'd4);
        // R4: store with load right only.
        slot("R4", 1, 1, 0, 64'h1000, 64'h100, 64'h0, LD_ONLY, 2'd1, 64'h0, 5'd4);
        // R4: fetch without fetch right, reserved kind.
        slot("R4", 1, 1, 0, 64'h2000, 64'h100, 64'h0, 31'h7FFF_FFFD, 2'd2, 64'h0, 5'd4);
        slot("R4", 1, 1, 0, 64'h2000, 64'h100, 64'h0, ALL, 2'd3, 64'h0, 5'd4);
        slot("R4", 1, 1, 0, 64'h2000, 64'h100, 64'h0, 31'h2, 2'd2, 64'h0, 5'd4);
        // R10: rights fault hides a bounds fault.
        slot("R10", 1, 1, 0, 64'h2000, 64'h10, 64'h800, 31'h0, 2'd0, 64'h0, 5'd8);
        // R5: last byte in, one past, below base.
        slot("R5", 1, 1, 0, 64'h1000, 64'h100, 64'hF8, ALL, 2'd0, 64'h0, 5'd8);
        slot("R5", 1, 1, 0, 64'h1000, 64'h100, 64'hF9, ALL, 2'd0, 64'h0, 5'd8);
        slot("R5", 1, 1, 0, 64'h1000, 64'h100, 64'h10, ALL, 2'd1, -64'sd32, 5'd1);
        // R6: crossing 2^64 with an oversized limit; ending exactly at 2^64.
        slot("R6", 1, 1, 0, 64'hFFFF_FFFF_FFFF_FF00, 64'h200, 64'hFC, ALL, 2'd0, 64'h0, 5'd8);
        slot("R6", 1, 1, 0, 64'hFFFF_FFFF_FFFF_FF00, 64'h200, 64'hF8, ALL, 2'd0, 64'h0, 5'd8);
        // R7: zero length.
        slot("R7", 1, 1, 0, 64'h3000, 64'h0, 64'h0, ALL, 2'd0, 64'h0, 5'd1);
        slot("R7", 1, 1, 0, 64'h3000, 64'h0, 64'h0, ALL, 2'd0, 64'h0, 5'd0);
        // R1: idle slot after a request.
        slot("R1", 0, 1, 0, 64'h3000, 64'h40, 64'h0, ALL, 2'd0, 64'h0, 5'd1);
        slot("R1", 0, 0, 0, 64'h0, 64'h0, 64'h0, 31'h0, 2'd0, 64'h0, 5'd0);
        // R8 R5: varied traffic.
        for (int i = 0; i < 400; i++) begin
            logic [63:0] b, l, o;
            b = {$urandom, $urandom};
            if (i % 4 == 0) b = 64'hFFFF_FFFF_FFFF_FF80;
            l = 64'($urandom_range(0, 64));
            o = 64'($urandom_range(0, 72));
            slot("R8", ($urandom_range(0, 5) != 0), ($urandom_range(0, 9) != 0),
                 ($urandom_range(0, 9) == 0), b, l, o, 31'($urandom),
                 2'($urandom_range(0, 3)), 64'($signed($urandom_range(0, 8)) - 4),
                 5'($urandom_range(0, 16)));
        end
        slot("R1", 0, 0, 0, 64'h0, 64'h0, 64'h0, 31'h0, 2'd0, 64'h0, 5'd0);
        @(negedge clk_i);
        compare();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule